// File: doc/BRIEF.md
# Iterative Half-Adder Adder with Completion Detection

This block adds two unsigned operands using only a single row of per-bit half adders. The row is reused over several clock cycles. On the first pass a multiplexer in front of each bit routes the operands into the half adders. On every later pass the multiplexers route back the previous sum vector, together with the previous carry vector moved up by one bit position. Passes repeat until no carry is left anywhere in the word, and the sum vector at that point is the answer.

A completion detector watches the carry vector and raises `done` once that vector is all zeros. The number of cycles therefore depends on the operands. Carry chains that do not overlap resolve side by side, so random operands finish in far fewer passes than the worst case.

A caller raises `req` with the operands stable and waits for `done`. It then reads `sum` and `cout` and lowers `req`, which clears `done`. While `req` is high the operands are sampled only once, at the start of the operation.

Top module: `iter_ha_adder`

## Requirements
- R1: After reset, `done`, `cout` and `sum` are all zero.
- R2: The first pass is a bitwise half-add of `a` and `b`. It is taken on the first rising edge at which `req` is high while the block is idle. `done` is low after that edge.
- R3: Each later pass forms the new sum as the old sum XOR (old carry << 1) and the new carry as the old sum AND (old carry << 1). Bit 0 gets a zero carry-in. When `done` rises, `sum` equals (a + b) mod 2^WIDTH.
- R4: A carry that leaves the most significant bit on any pass sets `cout`, and `cout` stays set for the rest of the operation. When `done` rises, `cout` equals the carry out of a + b.
- R5: `done` rises exactly P rising edges after the accepting edge, where P is the number of passes needed for the carry vector to become zero. While `done` is high, no carry remains.
- R6: The worst case, all ones plus one, takes WIDTH+1 passes.
- R7: Adding operands that produce no carry on the first pass (for example zero plus zero) takes one pass. `done` then rises on the edge after the accepting edge.
- R8: While `done` and `req` are both high, `done` stays high and `sum` and `cout` hold. One edge after `req` is seen low, `done` is low.
- R9: Changing `a` or `b` after the accepting edge has no effect on the result. Holding `req` high after `done` does not start a new operation.
- R10: In no bit position are the registered carry bit and the registered sum bit both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request; held high until done, then lowered |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| sum | output | WIDTH | Result, valid while done is high |
| cout | output | 1 | Carry out of the addition, valid while done is high |
| done | output | 1 | Completion: every internal carry is zero |

## Verification
The bench aims at the ends of the latency range. Zero plus zero must finish after one pass; a design that skipped the zero test on the first carry vector would take an extra cycle. All ones plus one must take WIDTH+1 passes; a design that dropped the carry leaving the top bit would report the wrong `cout`, and one that stopped a pass early would return a partial sum. The bench also changes the operands in the middle of an operation and holds `req` high after `done`. A design that kept the multiplexers on the operands, or that restarted without a low `req` in between, would return a different sum or drop `done`.

// File: rtl/iter_ha_adder.sv
module iter_ha_adder #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             done
);

  typedef enum logic [1:0] {IDLE, RUN, HOLD} state_t;

  state_t           state;
  logic [WIDTH-1:0] s_q, c_q;
  logic             cout_q;

  // select makes one 0->1 transition per operation: operands first, feedback after
  logic             sel;
  logic [WIDTH-1:0] ha_x, ha_y, ha_s, ha_c;

  assign sel  = (state == RUN);
  assign ha_x = sel ? s_q : a;
  assign ha_y = sel ? (c_q << 1) : b;
  assign ha_s = ha_x ^ ha_y;
  assign ha_c = ha_x & ha_y;

  wire start   = (state == IDLE) && req;
  wire settled = (c_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= IDLE;
      s_q    <= '0;
      c_q    <= '0;
      cout_q <= 1'b0;
    end else begin
      unique case (state)
        IDLE: if (start) begin
          s_q    <= ha_s;
          c_q    <= ha_c;
          cout_q <= ha_c[WIDTH-1];
          state  <= RUN;
        end
        RUN: if (settled) begin
          state <= HOLD;
        end else begin
          s_q    <= ha_s;
          c_q    <= ha_c;
          cout_q <= cout_q | ha_c[WIDTH-1];
        end
        HOLD: if (!req) state <= IDLE;
        default: state <= IDLE;
      endcase
    end
  end

  assign sum  = s_q;
  assign cout = cout_q;
  assign done = (state == HOLD);

  assert_no_done_on_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);

  assert_done_no_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (c_q == '0));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && req) |=> (done && $stable(sum) && $stable(cout)));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !req) |=> !done);

  assert_no_11_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (s_q & c_q) == '0);

  assert_cout_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cout && !done && state != IDLE) |=> cout);

endmodule

// File: tb/iter_ha_adder_tb_top.sv
module iter_ha_adder_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic [W-1:0] sum;
  logic         cout, done;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  iter_ha_adder #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .a(a), .b(b),
    .sum(sum), .cout(cout), .done(done)
  );

  task automatic chk(input bit ok, input string req_tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  // number of passes from the recurrence in R3
  function automatic int exp_passes(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W-1:0] s = x ^ y, c = x & y, sh;
    int p = 1;
    while (c != '0) begin
      sh = c << 1;
      c  = s & sh;
      s  = s ^ sh;
      p++;
    end
    return p;
  endfunction

  task automatic run_op(input logic [W-1:0] x, input logic [W-1:0] y, input string tag,
                        input bit disturb);
    logic [W:0] ref_v = {1'b0, x} + {1'b0, y};
    int p = exp_passes(x, y);
    int n = 0;
    a = x; b = y; req = 1'b1;
    while (n < W + 6) begin
      @(posedge clk); n++;
      #1;
      if (n == 1) begin
        chk(!done, "R2", done, 0);
        if (disturb) begin a = ~x; b = x; end
      end
      if (done) break;
    end
    chk(n == p + 1, {tag, " latency R5"}, n - 1, p);
    chk(sum == ref_v[W-1:0], {tag, " sum R3"}, sum, ref_v[W-1:0]);
    chk(cout == ref_v[W], {tag, " cout R4"}, cout, ref_v[W]);
    @(negedge clk);
    req = 1'b0;
    @(posedge clk); #1;
    chk(!done, "R8 clear", done, 0);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #2;
    chk(!done && !cout && sum == '0, "R1", {sum, cout, done}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    run_op('0, '0, "R7 zero", 1'b0);
    run_op(16'h00F0, 16'h0F00, "R7 disjoint", 1'b0);
    run_op('1, 16'h0001, "R6 worst", 1'b0);
    chk(exp_passes('1, 16'h0001) == W + 1, "R6 passes", exp_passes('1, 16'h0001), W + 1);
    run_op(16'h0001, '1, "R6 swapped", 1'b0);
    run_op('1, '1, "R4 max", 1'b0);
    run_op(16'h8000, 16'h8000, "R4 top", 1'b0);
    run_op(16'h1234, 16'h4321, "R9 disturb", 1'b1);

    begin : hold_test
      logic [W:0] ref_v = 17'h0FFFF + 17'h00011;
      int n = 0;
      a = 16'hFFFF; b = 16'h0011; req = 1'b1;
      while (!done && n < W + 6) begin @(posedge clk); n++; #1; end
      a = 16'h0F0F; b = 16'h7777;
      for (int k = 0; k < 5; k++) begin @(posedge clk); #1; end
      chk(done, "R9 held req", done, 1);
      chk(sum == ref_v[W-1:0], "R8 sum held", sum, ref_v[W-1:0]);
      chk(cout == ref_v[W], "R8 cout held", cout, ref_v[W]);
      @(negedge clk); req = 1'b0;
      @(posedge clk); #1;
      chk(!done, "R8 clear after hold", done, 0);
      @(negedge clk);
    end

    for (int i = 0; i < 60; i++) begin
      logic [W-1:0] x = W'($urandom);
      logic [W-1:0] y = W'($urandom);
      run_op(x, y, "R3 random", (i % 7) == 3);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule